// File: doc/BRIEF.md
# Narrow-Path Block Cipher Operand Bridge

This block lets a host that owns only a few slow, general-purpose signal lines drive a 128-bit block-cipher engine. The host writes a 25-line inbound word: sixteen data lines plus nine control lines. The bridge steers each 16-bit piece into one of eight slice positions of a plaintext register, a key register, or both. A start command then launches the engine. When the engine signals completion, the bridge captures the 128-bit result and presents one 16-bit slice of it, chosen by the same slice index, on an 18-line outbound word together with a busy flag and a done flag.

Every inbound line passes through a two-stage synchroniser. The load and start commands act on rising edges only, so each software toggle causes exactly one action. The sequencer has four states. ST_IDLE waits for a start edge. ST_LAUNCH drives the single-cycle engine start. ST_WAIT waits for the engine's completion pulse. ST_DONE holds the result flag.

The transitions are: ST_IDLE to ST_LAUNCH on a start edge; ST_LAUNCH to ST_WAIT unconditionally; ST_WAIT to ST_DONE on engine completion; ST_DONE to ST_LAUNCH on a start edge. A status clear returns any state to ST_IDLE.

Top module: `wide_cipher_bridge`

## Requirements
- R1: Inbound line map after synchronisation: in_lines[15:0] data, [18:16] slice index (0 to 7), [19] write plaintext, [20] write key, [21] load, [22] start, [24:23] clear. Outbound map: out_lines[15:0] result slice, [16] busy, [17] done.
- R2: A rising edge on load writes the data into the indexed slice of every operand whose write bit is set. Slice 0 is bits 15:0. Other slices are unchanged, a load with both write bits at 0 changes nothing, and holding load high writes only once. The operand registers drive core_text and core_key continuously.
- R3: A rising edge on start in ST_IDLE or ST_DONE raises core_start for exactly one clock cycle.
- R4: A rising edge on start while busy is ignored and produces no core_start pulse.
- R5: Busy is high from the core_start cycle until the cycle in which core_done is seen. Done is high after that and stays high until the next start edge or a status clear. Busy and done are never high together.
- R6: When core_done arrives in ST_WAIT, core_result is captured, and out_lines[15:0] shows the indexed 16-bit slice of the captured value. A core_done pulse in any other state is ignored.
- R7: Clear bit 23 zeroes both operand registers. Clear bit 24 zeroes the result register, drops busy and done, and returns the sequencer to ST_IDLE. A clear takes priority over a load or a start in the same cycle.
- R8: After reset, all outbound lines, core_start and both operand registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_lines | input | 25 | Inbound data and control lines from the host |
| out_lines | output | 18 | Outbound result slice and status lines |
| core_start | output | 1 | Single-cycle launch pulse to the cipher engine |
| core_key | output | 128 | Key operand |
| core_text | output | 128 | Plaintext operand |
| core_done | input | 1 | Completion pulse from the cipher engine |
| core_result | input | 128 | Cipher engine result |

## Verification
Directed loads walk the slices in order and then out of order. One case holds load high while the data changes, which separates edge-triggered writes from level-triggered ones. Write-mask codes 00 and 11 confirm that a load without a target has no effect and that a dual target writes both operands.

Start toggles during a long engine latency separate an edge-filtered launch from a retriggerable one. Stray completion pulses in ST_DONE and after a clear show that capture happens only in ST_WAIT. The two clear lines are exercised one at a time to show that each reaches only its own registers.

Randomised operands and engine latencies from 1 to 12 cycles then test every result slice against a bench model of the engine.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2,
        ST_DONE   = 2'd3
    } wcb_state_e;

    // Control field of the inbound word, MSB first
    typedef struct packed {
        logic [1:0] clr;    // [1] status/result clear, [0] operand clear
        logic       start;
        logic       load;
        logic [1:0] wmask;  // [1] key, [0] plaintext
        logic [2:0] idx;
    } wcb_ctrl_t;

    localparam int CTRL_W = $bits(wcb_ctrl_t);
    localparam int SLICES = 8;

endpackage

// File: rtl/wcb_sync.sv
module wcb_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/wcb_slice_reg.sv
module wcb_slice_reg #(
    parameter int DATA_W = 16,
    parameter int SLICES = 8,
    parameter int IDX_W  = $clog2(SLICES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     ld_en,
    input  logic [DATA_W*SLICES-1:0] ld_data,
    output logic [DATA_W*SLICES-1:0] q
);

    for (genvar g = 0; g < SLICES; g++) begin : g_slot
        logic [DATA_W-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                slot_q <= '0;
            else if (clr)                              slot_q <= '0;
            else if (ld_en)                            slot_q <= ld_data[g*DATA_W +: DATA_W];
            else if (wr_en && wr_idx == IDX_W'(g))     slot_q <= wr_data;
        end

        assign q[g*DATA_W +: DATA_W] = slot_q;
    end

endmodule

// File: rtl/wcb_ctrl.sv
module wcb_ctrl
    import wcb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic start_rise,
    input  logic core_done,
    output logic core_start,
    output logic busy,
    output logic done,
    output logic capture
);

    wcb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (start_rise) state_d = ST_LAUNCH;
                ST_LAUNCH: state_d = ST_WAIT;
                ST_WAIT:   if (core_done) state_d = ST_DONE;
                ST_DONE:   if (start_rise) state_d = ST_LAUNCH;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        core_start = 1'b0;
        busy       = 1'b0;
        done       = 1'b0;
        capture    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_LAUNCH: begin core_start = 1'b1; busy = 1'b1; end
            ST_WAIT:   begin busy = 1'b1; capture = core_done && !abort; end
            ST_DONE:   done = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/wide_cipher_bridge.sv
module wide_cipher_bridge
    import wcb_pkg::*;
#(
    parameter  int DATA_W      = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int BLOCK_W     = DATA_W * SLICES,
    localparam int IN_W        = DATA_W + CTRL_W,
    localparam int OUT_W       = DATA_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IN_W-1:0]    in_lines,
    output logic [OUT_W-1:0]   out_lines,
    output logic               core_start,
    output logic [BLOCK_W-1:0] core_key,
    output logic [BLOCK_W-1:0] core_text,
    input  logic               core_done,
    input  logic [BLOCK_W-1:0] core_result
);

    localparam int IDX_W = $clog2(SLICES);

    logic [IN_W-1:0]   lines_s;
    wcb_ctrl_t         ctl_s;
    logic [DATA_W-1:0] data_s;
    logic              load_p, start_p;
    logic              load_rise, start_rise;
    logic              clr_ops, clr_res;
    logic              busy, done, capture;
    logic [BLOCK_W-1:0] result_q;

    wcb_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (in_lines),
        .q     (lines_s)
    );

    assign ctl_s  = wcb_ctrl_t'(lines_s[IN_W-1:DATA_W]);
    assign data_s = lines_s[DATA_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_p  <= 1'b0;
            start_p <= 1'b0;
        end else begin
            load_p  <= ctl_s.load;
            start_p <= ctl_s.start;
        end
    end

    assign load_rise  = ctl_s.load  && !load_p;
    assign start_rise = ctl_s.start && !start_p;
    assign clr_ops    = ctl_s.clr[0];
    assign clr_res    = ctl_s.clr[1];

    wcb_slice_reg #(.DATA_W(DATA_W), .SLICES(SLICES)) u_text (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_ops),
        .wr_en   (load_rise && ctl_s.wmask[0]),
        .wr_idx  (ctl_s.idx),
        .wr_data (data_s),
        .ld_en   (1'b0),
        .ld_data ('0),
        .q       (core_text)
    );

    wcb_slice_reg #(.DATA_W(DATA_W), .SLICES(SLICES)) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_ops),
        .wr_en   (load_rise && ctl_s.wmask[1]),
        .wr_idx  (ctl_s.idx),
        .wr_data (data_s),
        .ld_en   (1'b0),
        .ld_data ('0),
        .q       (core_key)
    );

    wcb_slice_reg #(.DATA_W(DATA_W), .SLICES(SLICES)) u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_res),
        .wr_en   (1'b0),
        .wr_idx  ({IDX_W{1'b0}}),
        .wr_data ({DATA_W{1'b0}}),
        .ld_en   (capture),
        .ld_data (core_result),
        .q       (result_q)
    );

    wcb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (clr_res),
        .start_rise (start_rise),
        .core_done  (core_done),
        .core_start (core_start),
        .busy       (busy),
        .done       (done),
        .capture    (capture)
    );

    assign out_lines = {done, busy, result_q[ctl_s.idx*DATA_W +: DATA_W]};

endmodule

// File: rtl/wcb_chk.sv
module wcb_chk #(
    parameter int DATA_W  = 16,
    parameter int BLOCK_W = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               core_start,
    input logic               core_done,
    input logic [BLOCK_W-1:0] core_key,
    input logic [BLOCK_W-1:0] core_text,
    input logic [DATA_W+1:0]  out_lines,
    input logic               clr_ops,
    input logic               clr_res,
    input logic               start_rise
);

    logic busy_o, done_o;
    assign busy_o = out_lines[DATA_W];
    assign done_o = out_lines[DATA_W+1];

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);                                          // R3
    AST_START_NOT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> !$past(busy_o));                                       // R4
    AST_BUSY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> busy_o);                                               // R5
    AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));                                                 // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !clr_res && !start_rise |=> done_o);                        // R5
    AST_CAPTURE_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !core_start && core_done && !clr_res |=> done_o);           // R6
    AST_CLEAR_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ops |=> (core_key == '0) && (core_text == '0));                   // R7
    AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_res |=> !busy_o && !done_o);                                      // R7

endmodule

bind wide_cipher_bridge wcb_chk #(.DATA_W(DATA_W), .BLOCK_W(BLOCK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_start (core_start),
    .core_done  (core_done),
    .core_key   (core_key),
    .core_text  (core_text),
    .out_lines  (out_lines),
    .clr_ops    (clr_ops),
    .clr_res    (clr_res),
    .start_rise (start_rise)
);

// File: tb/wide_cipher_bridge_bench.sv
module wide_cipher_bridge_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [24:0]  in_lines = '0;
    logic [17:0]  out_lines;
    logic         core_start;
    logic [127:0] core_key, core_text;
    logic         core_done = 1'b0;
    logic [127:0] core_result = '0;

    always #2 clk = ~clk;   // 250 MHz

    wide_cipher_bridge u_wide_cipher_bridge (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_lines    (in_lines),
        .out_lines   (out_lines),
        .core_start  (core_start),
        .core_key    (core_key),
        .core_text   (core_text),
        .core_done   (core_done),
        .core_result (core_result)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Inbound fields
    logic [1:0]  f_clr = '0;
    logic        f_start = 1'b0, f_load = 1'b0;
    logic [1:0]  f_mask = '0;
    logic [2:0]  f_idx = '0;
    logic [15:0] f_data = '0;

    // Bench reference state
    logic [127:0] exp_text = '0, exp_key = '0, exp_res = '0;

    // Engine model
    int           lat_cfg = 4;
    int           lat_cnt = 0;
    int           n_start = 0;
    int           run_len = 0, max_run = 0;
    int           inj_req = 0, inj_ack = 0;
    logic [127:0] inj_val = '0;
    logic [127:0] seen_key = '0, seen_text = '0;

    function automatic logic [127:0] engine_fn(logic [127:0] k, logic [127:0] t);
        return {t[63:0], t[127:64]} ^ k ^ {4{32'h9e3779b9}};
    endfunction

    always @(negedge clk) begin
        core_done = 1'b0;
        if (core_start) begin
            run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
        if (inj_req != inj_ack) begin
            core_done   = 1'b1;
            core_result = inj_val;
            inj_ack++;
        end else if (core_start) begin
            n_start++;
            seen_key  = core_key;
            seen_text = core_text;
            lat_cnt   = lat_cfg;
        end else if (lat_cnt != 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                core_done   = 1'b1;
                core_result = engine_fn(seen_key, seen_text);
            end
        end
    end

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply();
        @(posedge clk); #1;
        in_lines = {f_clr, f_start, f_load, f_mask, f_idx, f_data};
        repeat (5) @(posedge clk);
        #1;
    endtask

    task automatic load_slice(logic [1:0] mask, logic [2:0] idx, logic [15:0] d);
        f_mask = mask; f_idx = idx; f_data = d; f_load = 1'b0; apply();
        f_load = 1'b1; apply();
        f_load = 1'b0; apply();
        if (mask[0]) exp_text[idx*16 +: 16] = d;
        if (mask[1]) exp_key[idx*16 +: 16]  = d;
    endtask

    task automatic wait_done(string req);
        int k;
        for (k = 0; k < 400; k++) begin
            if (out_lines[17]) break;
            @(posedge clk); #1;
        end
        chk(out_lines[17] === 1'b1, req, {127'd0, out_lines[17]}, 128'd1);
    endtask

    task automatic check_result(string req);
        for (int s = 0; s < 8; s++) begin
            f_idx = 3'(s); apply();
            chk(out_lines[15:0] === exp_res[s*16 +: 16], req,
                {112'd0, out_lines[15:0]}, {112'd0, exp_res[s*16 +: 16]});
        end
    endtask

    task automatic inject(logic [127:0] v);
        inj_val = v;
        inj_req++;
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int base;
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;

        // R8 reset state
        chk(out_lines === '0, "R8", {110'd0, out_lines}, 128'd0);
        chk(core_start === 1'b0 && n_start == 0, "R8", {127'd0, core_start}, 128'd0);
        chk(core_key === '0 && core_text === '0, "R8", core_key | core_text, 128'd0);

        // R2 in-order plaintext slices, key untouched
        for (int i = 0; i < 8; i++) load_slice(2'b01, 3'(i), 16'h1100 + 16'(i));
        chk(core_text === exp_text, "R2", core_text, exp_text);
        chk(core_key === '0, "R2", core_key, 128'd0);

        // R2 out-of-order key slices
        for (int i = 0; i < 8; i++) load_slice(2'b10, 3'((i * 3 + 5) % 8), 16'($urandom));
        chk(core_key === exp_key, "R2", core_key, exp_key);

        // R2 held load writes once
        f_mask = 2'b01; f_idx = 3'd3; f_data = 16'hAAAA; f_load = 1'b1; apply();
        f_data = 16'h5555; apply();
        f_load = 1'b0; apply();
        exp_text[48 +: 16] = 16'hAAAA;
        chk(core_text === exp_text, "R2", core_text, exp_text);

        // R2 empty mask has no effect, dual mask writes both
        load_slice(2'b00, 3'd0, 16'hDEAD);
        chk(core_text === exp_text && core_key === exp_key, "R2", core_text ^ core_key, exp_text ^ exp_key);
        load_slice(2'b11, 3'd5, 16'hBEEF);
        chk(core_text === exp_text && core_key === exp_key, "R2", core_text ^ core_key, exp_text ^ exp_key);

        // R3 R4 R5 long-latency launch with a retrigger attempt
        lat_cfg = 40;
        base = n_start;
        f_start = 1'b1; apply();
        chk(n_start == base + 1, "R3", 128'(n_start - base), 128'd1);
        chk(out_lines[17:16] === 2'b01, "R5", {126'd0, out_lines[17:16]}, 128'd1);
        f_start = 1'b0; apply();
        f_start = 1'b1; apply();
        f_start = 1'b0; apply();
        chk(n_start == base + 1, "R4", 128'(n_start - base), 128'd1);
        wait_done("R5");
        chk(max_run == 1, "R3", 128'(max_run), 128'd1);
        chk(out_lines[16] === 1'b0, "R5", {127'd0, out_lines[16]}, 128'd0);
        chk(seen_key === exp_key && seen_text === exp_text, "R2", seen_key ^ seen_text, exp_key ^ exp_text);
        exp_res = engine_fn(exp_key, exp_text);
        check_result("R6");

        // R6 stray completion in ST_DONE ignored
        inject(~exp_res);
        check_result("R6");
        chk(out_lines[17] === 1'b1, "R5", {127'd0, out_lines[17]}, 128'd1);

        // R5 next start drops done
        lat_cfg = 40;
        f_start = 1'b1; apply();
        chk(out_lines[17:16] === 2'b01, "R5", {126'd0, out_lines[17:16]}, 128'd1);
        f_start = 1'b0; apply();
        wait_done("R5");

        // R7 status clear only
        f_clr = 2'b10; apply();
        f_clr = 2'b00; apply();
        exp_res = '0;
        chk(out_lines === '0, "R7", {110'd0, out_lines}, 128'd0);
        chk(core_key === exp_key, "R7", core_key, exp_key);
        // R7 operand clear only
        load_slice(2'b01, 3'd1, 16'h7777);
        f_clr = 2'b01; apply();
        f_clr = 2'b00; apply();
        exp_text = '0; exp_key = '0;
        chk(core_key === '0 && core_text === '0, "R7", core_key | core_text, 128'd0);

        // R7 R6 clear during a run, late completion ignored
        lat_cfg = 40;
        f_start = 1'b1; apply();
        f_clr = 2'b10; f_start = 1'b0; apply();
        f_clr = 2'b00; apply();
        chk(out_lines[17:16] === 2'b00, "R7", {126'd0, out_lines[17:16]}, 128'd0);
        repeat (50) @(posedge clk);
        #1;
        chk(out_lines[17:16] === 2'b00, "R6", {126'd0, out_lines[17:16]}, 128'd0);
        check_result("R6");

        // R1 R2 R5 R6 randomised operands and latencies
        for (int it = 0; it < 25; it++) begin
            int off = int'($urandom % 8);
            for (int i = 0; i < 8; i++) load_slice(2'b01, 3'((i + off) % 8), 16'($urandom));
            for (int i = 0; i < 8; i++) load_slice(2'b10, 3'((i + off) % 8), 16'($urandom));
            lat_cfg = 1 + int'($urandom % 12);
            f_start = 1'b1; apply();
            f_start = 1'b0; apply();
            wait_done("R5");
            chk(seen_key === exp_key && seen_text === exp_text, "R1", seen_key ^ seen_text, exp_key ^ exp_text);
            exp_res = engine_fn(exp_key, exp_text);
            check_result("R6");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule